// File: doc/BRIEF.md
# Cascaded Prescaler Timer

This block is a two-stage up-counting timer. A prescale counter advances on every enabled input step; when it sits at its own period value, the next step returns it to zero and produces a tick. That tick advances the main timer counter by one. When the timer reaches its active period, the block raises an interrupt request and a DMA event request. A prescale period of P therefore divides the step rate by P+1.

A mode input selects one of two prescaler widths. Wide mode uses the full 32-bit prescaler, and in this mode the prescaler may be stepped by an external pulse. Narrow mode uses a 4-bit prescaler and is always stepped by the internal clock. Both variants share one datapath. In narrow mode only, the timer stage can replace its active period with a reload value each time it wraps. Both counts can be preset through a load strobe, cleared through a synchronous clear, and held by removing the enable.

Top module: `casc_tick_timer`

## Requirements
- R1: After reset, prescale count, timer count and active period all read 0, and tick, irq and dma_evt are low.
- R2: A clear sets both counts to 0 and copies tmr_period into the active period. A load presets the counts from pre_init and tmr_init and also copies tmr_period. If clear and load are high together, clear takes effect.
- R3: While enable is low and neither clear nor load is high, both counts hold their values.
- R4: On each step, the prescale count increments by one. A step taken while the count equals the prescale period returns it to 0. For example, count 200 with period 202 gives 200, 201, 202, 0.
- R5: Each prescaler return to 0 advances the timer count by one in the same clock edge. The tick output is high for the cycle that follows that edge.
- R6: A tick taken while the timer count equals the active period returns the timer to 0. For example, count 15 with period 16 gives 15, 16, 0.
- R7: irq and dma_evt are high for one cycle exactly when a tick leaves the timer equal to the active period. This includes a period of 0.
- R8: When narrow_mode=1, only bits [3:0] of pre_period are used, and the prescale count stays within 4 bits (its bits [31:4] are 0).
- R9: When narrow_mode=0 and ext_sel=1, the prescaler steps only in cycles where ext_pulse is high. When narrow_mode=1, ext_sel is ignored and the prescaler steps every enabled cycle.
- R10: When narrow_mode=1 and reload_on=1, the active period takes tmr_reload at each timer wrap. When narrow_mode=0, the active period never changes on a wrap.
- R11: narrow_mode does not change between two consecutive enabled cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Count enable |
| clear | input | 1 | Synchronous clear of both counts |
| load | input | 1 | Preset both counts |
| narrow_mode | input | 1 | 1 selects the 4-bit prescaler, 0 selects the 32-bit prescaler |
| ext_sel | input | 1 | Wide mode: step the prescaler from ext_pulse |
| ext_pulse | input | 1 | External step pulse |
| reload_on | input | 1 | Narrow mode: reload the active period at each wrap |
| pre_period | input | 32 | Prescale period |
| tmr_period | input | 32 | Timer period, copied on clear or load |
| tmr_reload | input | 32 | Period reload value |
| pre_init | input | 32 | Prescale preset |
| tmr_init | input | 32 | Timer preset |
| pre_count | output | 32 | Prescale count |
| tmr_count | output | 32 | Timer count |
| act_period | output | 32 | Active timer period |
| tick | output | 1 | Prescaler wrap pulse |
| irq | output | 1 | Interrupt request |
| dma_evt | output | 1 | DMA event request |

## Verification
A wrong prescale count shows on pre_count at the very next edge. It also shifts every later tick, so a division ratio that is off by one moves the tick a full step within one prescale period. A timer or active-period error shows on tmr_count or act_period at the first tick after the fault. A missed or extra match appears on irq one cycle after that tick. Random runs are compared against a cycle model on every cycle, so any divergence is reported at the cycle it first becomes visible.

// File: rtl/casc_tick_timer.sv
module casc_tick_timer #(
  parameter int CW = 32,
  parameter int NW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          clear,
  input  logic          load,
  input  logic          narrow_mode,
  input  logic          ext_sel,
  input  logic          ext_pulse,
  input  logic          reload_on,
  input  logic [CW-1:0] pre_period,
  input  logic [CW-1:0] tmr_period,
  input  logic [CW-1:0] tmr_reload,
  input  logic [CW-1:0] pre_init,
  input  logic [CW-1:0] tmr_init,
  output logic [CW-1:0] pre_count,
  output logic [CW-1:0] tmr_count,
  output logic [CW-1:0] act_period,
  output logic          tick,
  output logic          irq,
  output logic          dma_evt
);

  localparam logic [CW-1:0] NMASK = {{(CW-NW){1'b0}}, {NW{1'b1}}};

  logic [CW-1:0] pre_q, tmr_q, per_q;
  logic          tick_q;

  wire [CW-1:0] pmask   = narrow_mode ? NMASK : '1;
  wire          step    = enable && (narrow_mode || !ext_sel || ext_pulse);
  wire          pre_hit = (pre_q == (pre_period & pmask));
  wire          wrap    = step && pre_hit;
  wire          tmr_hit = (tmr_q == per_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      tmr_q  <= '0;
      per_q  <= '0;
      tick_q <= 1'b0;
    end else if (clear) begin
      pre_q  <= '0;
      tmr_q  <= '0;
      per_q  <= tmr_period;
      tick_q <= 1'b0;
    end else if (load) begin
      pre_q  <= pre_init & pmask;
      tmr_q  <= tmr_init;
      per_q  <= tmr_period;
      tick_q <= 1'b0;
    end else begin
      tick_q <= wrap;
      if (step)
        pre_q <= pre_hit ? '0 : ((pre_q + 1'b1) & pmask);
      if (wrap) begin
        tmr_q <= tmr_hit ? '0 : tmr_q + 1'b1;
        if (tmr_hit && narrow_mode && reload_on)
          per_q <= tmr_reload;
      end
    end
  end

  assign pre_count  = pre_q;
  assign tmr_count  = tmr_q;
  assign act_period = per_q;
  assign tick       = tick_q;
  assign irq        = tick_q && tmr_hit;
  assign dma_evt    = irq;

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !clear && !load) |=> (pre_q == $past(pre_q) && tmr_q == $past(tmr_q)));

  assert_tick_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |-> (pre_q == '0));

  assert_tmr_still_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrap && !clear && !load) |=> $stable(tmr_q));

  assert_tmr_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && tmr_hit && !clear && !load) |=> (tmr_q == '0));

  assert_narrow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (narrow_mode && step && !clear && !load) |=> (pre_q[CW-1:NW] == '0));

  assert_mode_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable)) |-> (narrow_mode == $past(narrow_mode)));

endmodule

// File: tb/sim_casc_tick_timer.sv
module sim_casc_tick_timer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic enable = 0, clear = 0, load = 0, narrow_mode = 0, ext_sel = 0, ext_pulse = 0, reload_on = 0;
  logic [31:0] pre_period = 0, tmr_period = 0, tmr_reload = 0, pre_init = 0, tmr_init = 0;
  logic [31:0] pre_count, tmr_count, act_period;
  logic tick, irq, dma_evt;
  int errors = 0, checks = 0;
  bit done = 0;

  logic [31:0] m_pre = 0, m_tmr = 0, m_act = 0;
  logic m_tick = 0;

  always #4 clk = ~clk;

  casc_tick_timer u0 (.*);

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_update();
    logic [31:0] pm;
    logic st, wr, th;
    pm = narrow_mode ? 32'hF : 32'hFFFF_FFFF;
    st = enable && (narrow_mode || !ext_sel || ext_pulse);
    wr = st && (m_pre == (pre_period & pm));
    th = (m_tmr == m_act);
    if (clear) begin
      m_pre = 0; m_tmr = 0; m_act = tmr_period; m_tick = 0;
    end else if (load) begin
      m_pre = pre_init & pm; m_tmr = tmr_init; m_act = tmr_period; m_tick = 0;
    end else begin
      m_tick = wr;
      if (st) m_pre = (m_pre == (pre_period & pm)) ? 0 : ((m_pre + 1) & pm);
      if (wr) begin
        m_tmr = th ? 0 : m_tmr + 1;
        if (th && narrow_mode && reload_on) m_act = tmr_reload;
      end
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  task automatic cmp_all();
    chk("R4 pre_count", pre_count, m_pre);
    chk("R5 tmr_count", tmr_count, m_tmr);
    chk("R10 act_period", act_period, m_act);
    chk("R5 tick", tick, m_tick);
    chk("R7 irq", irq, m_tick && (m_tmr == m_act));
    chk("R7 dma_evt", dma_evt, m_tick && (m_tmr == m_act));
  endtask

  task automatic do_load(logic [31:0] p, logic [31:0] t);
    pre_init = p; tmr_init = t; load = 1;
    cyc();
    load = 0;
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (2) @(negedge clk);
    // R1
    chk("R1 pre", pre_count, 0); chk("R1 tmr", tmr_count, 0);
    chk("R1 per", act_period, 0); chk("R1 irq", {tick, irq, dma_evt}, 0);
    rst_n = 1;
    @(negedge clk);

    // R4/R5/R7 wide example
    pre_period = 202; tmr_period = 4;
    do_load(200, 3);
    chk("R2 load pre", pre_count, 200); chk("R2 load tmr", tmr_count, 3);
    chk("R2 load per", act_period, 4);
    enable = 1;
    cyc(); chk("R4 seq 201", pre_count, 201);
    cyc(); chk("R4 seq 202", pre_count, 202); chk("R5 no adv", tmr_count, 3);
    cyc(); chk("R4 seq 0", pre_count, 0); chk("R5 adv", tmr_count, 4);
    chk("R5 tick", tick, 1); chk("R7 irq", irq, 1); chk("R7 dma", dma_evt, 1);
    cyc(); chk("R5 tick once", tick, 0); chk("R7 irq once", irq, 0);

    // R3 hold
    enable = 0;
    repeat (5) cyc();
    chk("R3 hold pre", pre_count, 1); chk("R3 hold tmr", tmr_count, 4);

    // R6/R8 narrow example
    narrow_mode = 1; pre_period = 2; tmr_period = 16;
    do_load(1, 15);
    enable = 1;
    cyc(); chk("R8 pre 2", pre_count, 2);
    cyc(); chk("R8 pre 0", pre_count, 0); chk("R6 tmr 16", tmr_count, 16); chk("R7 irq", irq, 1);
    cyc(); cyc(); cyc(); chk("R6 tmr 0", tmr_count, 0); chk("R7 no irq at 0", irq, 0);

    // R8 upper period bits ignored
    enable = 0; pre_period = 32'h1F3;
    do_load(0, 0);
    enable = 1;
    repeat (3) cyc(); chk("R8 pre 3", pre_count, 3);
    cyc(); chk("R8 pre wraps", pre_count, 0); chk("R8 tick", tick, 1);

    // R9 external stepping
    enable = 0; narrow_mode = 0; pre_period = 100;
    do_load(5, 0);
    enable = 1; ext_sel = 1; ext_pulse = 0;
    repeat (3) cyc(); chk("R9 no pulse", pre_count, 5);
    ext_pulse = 1; cyc(); ext_pulse = 0; chk("R9 pulse", pre_count, 6);
    enable = 0; cyc(); narrow_mode = 1; pre_period = 9; enable = 1;
    cyc(); chk("R9 narrow ignores ext", pre_count, 7);

    // R10 reload
    enable = 0; ext_sel = 0; reload_on = 1; pre_period = 0; tmr_period = 1; tmr_reload = 3;
    do_load(0, 0);
    enable = 1;
    cyc(); chk("R10 tmr 1", tmr_count, 1); chk("R7 irq", irq, 1);
    cyc(); chk("R10 wrap", tmr_count, 0); chk("R10 reloaded", act_period, 3);
    enable = 0; cyc(); narrow_mode = 0;
    do_load(0, 0);
    enable = 1;
    cyc(); cyc(); chk("R10 wide no reload", act_period, 1);
    // R7 period 0
    enable = 0; tmr_period = 0;
    do_load(0, 0);
    enable = 1;
    cyc(); chk("R7 period0 irq", irq, 1); chk("R7 period0 tmr", tmr_count, 0);

    // R2 clear beats load
    tmr_period = 7; clear = 1; load = 1; pre_init = 9; tmr_init = 9;
    cyc(); clear = 0; load = 0;
    chk("R2 clear pre", pre_count, 0); chk("R2 clear tmr", tmr_count, 0);
    chk("R2 clear per", act_period, 7);

    // sync model to DUT state, then random
    m_pre = pre_count; m_tmr = tmr_count; m_act = act_period; m_tick = tick;
    for (int i = 0; i < 4000; i++) begin
      logic en_n;
      en_n = ($urandom_range(0, 9) != 0);
      if (!en_n && $urandom_range(0, 3) == 0) narrow_mode = $urandom_range(0, 1);
      enable = en_n;
      clear = ($urandom_range(0, 99) == 0);
      load = ($urandom_range(0, 49) == 0);
      ext_sel = $urandom_range(0, 1);
      ext_pulse = $urandom_range(0, 1);
      reload_on = $urandom_range(0, 1);
      pre_period = $urandom_range(0, 6) | ($urandom_range(0, 1) << 8);
      tmr_period = $urandom_range(0, 5);
      tmr_reload = $urandom_range(0, 5);
      pre_init = $urandom_range(0, 5);
      tmr_init = $urandom_range(0, 5);
      cyc();
      cmp_all();
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule